// File: doc/BRIEF.md
# Bus Acknowledge Wait-State Generator

This block produces the active-low transfer acknowledge for an asynchronous, strobe-based processor bus. It holds a down-counter. While the address strobe is inactive (high), the counter reloads from a wait-count input on every clock. When the strobe falls and the device is selected, the counter runs down toward zero. The clock after it reaches zero, the acknowledge goes low. The acknowledge then stays low until the strobe rises again.

A wait count of zero gives fast memory an acknowledge with no added wait states. A larger count stretches the bus cycle for slower devices. Once the acknowledge is latched inside the block, the output is still gated by the live strobe and the live select. As a result, the acknowledge is released in the same cycle the strobe rises, with no clock edge in between.

Top module: `dtack_waitgen`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) forces ack_n high and loads the counter from wait_cnt. The counter therefore starts from the preset when the first strobe follows reset.
- R2: While strobe_n is high, the counter reloads from wait_cnt at every clock edge. Only the value present at the last edge before strobe_n falls takes effect.
- R3: With a preset of 0, ack_n goes low after the first clock edge at which strobe_n is sampled low with sel high.
- R4: With a preset of N (0 to 15, 4 bits), ack_n goes low after the (N+1)th clock edge at which strobe_n is low and sel is high. Before that edge it stays high.
- R5: Once asserted, ack_n stays low while strobe_n stays low and sel stays high. It returns high combinationally in the same cycle strobe_n rises.
- R6: ack_n is driven low only while sel is high. Clock edges with strobe_n low and sel low do not advance the count.
- R7: Changes of wait_cnt while strobe_n is low have no effect on the current cycle's acknowledge timing.
- R8: The largest preset, 15, holds off the acknowledge for 15 extra clocks (16 edges in total), stretching the bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_n | input | 1 | Address strobe, active low |
| sel | input | 1 | Device select from the address decoder, active high |
| wait_cnt | input | WAIT_W (4) | Wait-state preset |
| ack_n | output | 1 | Transfer acknowledge, active low |

## Verification
A wrong counter value shows up at the port only as an acknowledge edge that lands one or more clocks early or late in the next strobed cycle. The bench therefore compares ack_n against a reference model on every clock, including the edges where the count is paused or reloading. A stuck acknowledge latch shows up one cycle later, either as ack_n failing to fall or as ack_n staying low into the next cycle. A broken combinational release shows up within the same cycle, so ack_n is also sampled just after each input change.

// File: rtl/dtack_waitgen_pkg.sv
package dtack_waitgen_pkg;
    parameter int WAIT_W_DEF = 4;

    typedef struct packed {
        logic ack;
    } ack_state_t;
endpackage

// File: rtl/dtack_wait_counter.sv
module dtack_wait_counter #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              run,
    input  logic [WAIT_W-1:0] preset,
    output logic              zero
);
    localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

    typedef struct packed {
        logic [WAIT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst || load) begin
            st_d.cnt = preset;
        end else if (run && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign zero = (st_q.cnt == '0);

    // R2: strobe high at an edge reloads the preset
    a_r2_reload: assert property (@(posedge clk) disable iff (rst)
        $past(load) |-> st_q.cnt == $past(preset));

    // R4: a running count steps down by one
    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        (!load && run && !zero) |=> st_q.cnt == $past(st_q.cnt) - ONE);

    // R6: a paused count holds
    a_r6_pause: assert property (@(posedge clk) disable iff (rst)
        (!load && !run) |=> $stable(st_q.cnt));
endmodule

// File: rtl/dtack_ack_stage.sv
module dtack_ack_stage
    import dtack_waitgen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    input  logic sel,
    input  logic zero,
    output logic ack_n
);
    ack_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst || strobe_n) begin
            st_d.ack = 1'b0;
        end else if (sel && zero) begin
            st_d.ack = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ack_n = ~(st_q.ack & ~strobe_n & sel);

    // R3: count at zero under a selected strobe latches the acknowledge
    a_r3_latch: assert property (@(posedge clk) disable iff (rst)
        (!strobe_n && sel && zero) |=> st_q.ack);

    // R5: latched acknowledge survives while the strobe stays low
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q.ack && !strobe_n) |=> st_q.ack);

    // R5: strobe high means acknowledge released now
    a_r5_release: assert property (@(posedge clk) disable iff (rst)
        strobe_n |-> ack_n);

    // R6: no acknowledge without select
    a_r6_select: assert property (@(posedge clk) disable iff (rst)
        !sel |-> ack_n);
endmodule

// File: rtl/dtack_waitgen.sv
module dtack_waitgen #(
    parameter int WAIT_W = dtack_waitgen_pkg::WAIT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_n,
    input  logic              sel,
    input  logic [WAIT_W-1:0] wait_cnt,
    output logic              ack_n
);
    logic cnt_zero;
    logic run_en;

    assign run_en = ~strobe_n & sel;

    dtack_wait_counter #(.WAIT_W(WAIT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load   (strobe_n),
        .run    (run_en),
        .preset (wait_cnt),
        .zero   (cnt_zero)
    );

    dtack_ack_stage u_ack (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (strobe_n),
        .sel      (sel),
        .zero     (cnt_zero),
        .ack_n    (ack_n)
    );

    // R1: the edge after reset leaves acknowledge negated
    a_r1_reset: assert property (@(posedge clk)
        $past(rst) |-> ack_n);
endmodule

// File: tb/sim_dtack_waitgen.sv
module sim_dtack_waitgen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strobe_n = 1'b1;
    logic       sel = 1'b0;
    logic [3:0] wait_cnt = 4'd0;
    logic       ack_n;

    int    n_vec = 0;
    int    n_bad = 0;
    string phase = "R1";

    int remaining = 0;
    bit acked = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dtack_waitgen u0 (
        .clk(clk), .rst(rst), .strobe_n(strobe_n), .sel(sel),
        .wait_cnt(wait_cnt), .ack_n(ack_n)
    );

    // behavioural reference: wait budget and acknowledge flag
    always @(posedge clk) begin
        if (rst || strobe_n) begin
            remaining = int'(wait_cnt);
            acked = 1'b0;
        end else if (sel) begin
            if (remaining == 0) acked = 1'b1;
            else remaining = remaining - 1;
        end
    end

    task automatic compare();
        logic exp_n;
        exp_n = !(acked && !strobe_n && sel);
        n_vec++;
        if (ack_n !== exp_n) begin
            n_bad++;
            $display("FAIL %s: ack_n=%b expected %b at %0t", phase, ack_n, exp_n, $time);
        end
    endtask

    // compare after the edge, apply new inputs, compare again (combinational path)
    task automatic drive(input logic s_n, input logic sl, input logic [3:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            strobe_n = s_n;
            sel = sl;
            wait_cnt = w;
            #1;
            compare();
        end
    endtask

    initial begin
        // R1: reset, then strobe straight away with preset 2
        wait_cnt = 4'd2;
        drive(1'b1, 1'b0, 4'd2, 1);
        rst = 1'b1;
        strobe_n = 1'b0;
        sel = 1'b1;
        @(negedge clk); compare();
        rst = 1'b0;
        drive(1'b0, 1'b1, 4'd2, 5);
        // R5: release on strobe rise
        phase = "R5";
        drive(1'b1, 1'b1, 4'd0, 2);
        // R3: zero wait
        phase = "R3";
        drive(1'b0, 1'b1, 4'd0, 4);
        drive(1'b1, 1'b0, 4'd5, 2);
        // R4: several presets
        phase = "R4";
        for (int p = 1; p < 6; p++) begin
            drive(1'b1, 1'b0, 4'(p), 2);
            drive(1'b0, 1'b1, 4'(p), p + 3);
        end
        // R2: preset changes while strobe high, last one wins
        phase = "R2";
        drive(1'b1, 1'b0, 4'd9, 1);
        drive(1'b1, 1'b0, 4'd1, 1);
        drive(1'b0, 1'b1, 4'd1, 4);
        // R7: preset changes mid-cycle ignored
        phase = "R7";
        drive(1'b1, 1'b0, 4'd3, 2);
        drive(1'b0, 1'b1, 4'd12, 1);
        drive(1'b0, 1'b1, 4'd0, 5);
        // R6: select low pauses the count and blocks ack
        phase = "R6";
        drive(1'b1, 1'b0, 4'd3, 2);
        drive(1'b0, 1'b1, 4'd3, 2);
        drive(1'b0, 1'b0, 4'd3, 4);
        drive(1'b0, 1'b1, 4'd3, 4);
        drive(1'b0, 1'b0, 4'd3, 2);
        drive(1'b0, 1'b1, 4'd3, 2);
        // R8: longest stretch
        phase = "R8";
        drive(1'b1, 1'b0, 4'd15, 2);
        drive(1'b0, 1'b1, 4'd15, 20);
        drive(1'b1, 1'b0, 4'd0, 2);
        // R5: hold over long low strobe then release
        phase = "R5";
        drive(1'b0, 1'b1, 4'd0, 6);
        drive(1'b1, 1'b1, 4'd0, 2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule